// File: doc/BRIEF.md
# Serial Boot Configuration Loader

At power-up this block reads a 256-bit serial configuration image, one bit at a time. It divides the system clock by a fixed ratio to make a slow mode clock and drives that clock out to the serial source. It takes one sample of the mode-in line on the last system cycle of each mode-clock period. Bits arrive least significant first. When the last bit has arrived, the block freezes the image. It then presents the decoded boot settings and a done flag, plus an error flag when the image uses a reserved bit or a reserved encoding.

A small state machine controls the sequence. It has three states. `LD_SHIFT` collects bits. `LD_CHECK` is a single cycle in which the decoded fields and the error result are latched. `LD_DONE` holds everything until reset. There are two transitions: `SHIFT_TO_CHECK` fires on the sample of the final bit, and `CHECK_TO_DONE` fires unconditionally on the next cycle. Only the low 25 image bits are stored. Reserved bits above them are checked as they stream past.

Top module: `boot_mode_loader`

## Requirements
- R1: While reset is held, and just after it is released, `cfg_done` and `cfg_err` are 0 and `mode_clk` is 1.
- R2: `mode_clk` has a period of DIV system cycles. It is high for the first DIV/2 cycles of each period. Each period starts on the first clock edge after reset is released.
- R3: Image bit k (0 to 255, bit 0 first) is sampled on clock edge (k+1)·DIV after reset release. `cfg_done` rises after edge 256·DIV+1 and then stays high until reset.
- R4: Until `cfg_done` is set, the decoded outputs hold fixed safe values: `wb_rate`=0, `mult_factor`=2, `wr_proto`=00, `timer_int_off`=0, `drive_code`=10, `wr_delay`=0.
- R5: `wb_rate` is taken from image bits 4..1. Values 9 to 15 set `cfg_err`.
- R6: `mult_factor` equals the code in image bits 7..5 plus 2, giving 2 to 8. Code 7 sets `cfg_err`.
- R7: `big_endian` is image bit 8 ORed with `big_endian_pin` once `cfg_done` is set. Before that it follows `big_endian_pin` alone.
- R8: `wr_proto` is taken from image bits 10..9, where 00 means compatible, 10 pipelined and 11 re-issue. The value 01 sets `cfg_err`.
- R9: `timer_int_off` equals image bit 11. A value of 1 masks the timer interrupt on line 5.
- R10: `drive_code` is taken from image bits 14..13. The code meanings are 10 for full strength, 11 for 83 %, 00 for 67 % and 01 for 50 %.
- R11: `wr_delay` is taken from image bits 24..22 and gives the write address to data delay in pipeline cycles.
- R12: A 1 in any of image bits 0, 12, 15, 19, 20, 21 or 25..255 sets `cfg_err`. Bits 16..18 are never flagged. Fields are latched even when `cfg_err` is set.
- R13: `cfg_err` rises only together with `cfg_done` and stays set until reset. After `cfg_done`, activity on `mode_in` changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_in | input | 1 | Serial configuration bit |
| big_endian_pin | input | 1 | External byte-order strap |
| mode_clk | output | 1 | Divided clock for the serial source |
| cfg_done | output | 1 | Image captured and decoded |
| cfg_err | output | 1 | Reserved bit or encoding seen |
| wb_rate | output | 4 | Write-back data rate code |
| mult_factor | output | 4 | Clock multiplier, 2 to 8 |
| big_endian | output | 1 | Effective byte order |
| wr_proto | output | 2 | Write protocol code |
| timer_int_off | output | 1 | Timer interrupt mask |
| drive_code | output | 2 | Output driver strength code |
| wr_delay | output | 3 | Write address to data delay |

## Verification
The assertions take for granted that `mode_in` is stable for at least four system cycles before each sampling edge, and that DIV is at least 5 so that this window exists. The bench changes `mode_in` only on the falling edge just after a sample, so every bit is stable for a whole mode-clock period. The bench overrides DIV to 8 so that many full 256-bit images fit in the run. The timing relations are stated in multiples of DIV, so they carry over unchanged to the default of 256.

// File: rtl/bootmode_pkg.sv
package bootmode_pkg;

    typedef enum logic [1:0] {
        LD_SHIFT = 2'd0,
        LD_CHECK = 2'd1,
        LD_DONE  = 2'd2
    } ld_state_t;

    typedef enum logic [1:0] {
        WP_COMPAT  = 2'b00,
        WP_RSVD    = 2'b01,
        WP_PIPE    = 2'b10,
        WP_REISSUE = 2'b11
    } wr_proto_t;

    localparam int IMG_KEEP     = 25;
    localparam int RATE_LO      = 1;
    localparam int MULT_LO      = 5;
    localparam int ENDIAN_POS   = 8;
    localparam int PROTO_LO     = 9;
    localparam int TIMER_POS    = 11;
    localparam int DRIVE_LO     = 13;
    localparam int DELAY_LO     = 22;
    localparam int RATE_MAX     = 8;
    localparam logic [1:0] DRIVE_DEFAULT = 2'b10;

    function automatic logic bit_is_reserved(input int idx);
        return (idx == 0) || (idx == 12) || (idx == 15) ||
               (idx >= 19 && idx <= 21) || (idx >= IMG_KEEP);
    endfunction

endpackage

// File: rtl/bm_clkdiv.sv
module bm_clkdiv #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic mode_clk,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF  = DIV / 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    assign tick    = (cnt == CNT_W'(DIV - 1));
    assign cnt_nxt = tick ? '0 : cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            mode_clk <= 1'b1;
        end else begin
            cnt      <= cnt_nxt;
            mode_clk <= (int'(cnt_nxt) < HALF);
        end
    end

    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    a_r2_clk_low_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !mode_clk);

endmodule

// File: rtl/bm_capture.sv
module bm_capture #(
    parameter int STREAM_BITS = 256,
    parameter int KEEP        = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    input  logic            mode_in,
    output logic [KEEP-1:0] image,
    output logic            rsv_hit,
    output logic            last_bit
);
    import bootmode_pkg::*;

    localparam int IDX_W = $clog2(STREAM_BITS);

    logic [IDX_W-1:0] idx;
    logic             take;

    assign take     = en && tick;
    assign last_bit = take && (idx == IDX_W'(STREAM_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            image   <= '0;
            rsv_hit <= 1'b0;
        end else if (take) begin
            idx <= idx + 1'b1;
            if (int'(idx) < KEEP)
                image[idx] <= mode_in;
            if (mode_in && bit_is_reserved(int'(idx)))
                rsv_hit <= 1'b1;
        end
    end

    a_r3_idx_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(idx));

endmodule

// File: rtl/bm_decode.sv
module bm_decode (
    input  logic [24:0] image,
    output logic [3:0]  rate,
    output logic [3:0]  factor,
    output logic        be_bit,
    output logic [1:0]  proto,
    output logic        tdis,
    output logic [1:0]  drive,
    output logic [2:0]  delay,
    output logic        enc_bad
);
    import bootmode_pkg::*;

    logic [2:0] mult_code;

    always_comb begin
        rate      = image[RATE_LO +: 4];
        mult_code = image[MULT_LO +: 3];
        factor    = {1'b0, mult_code} + 4'd2;
        be_bit    = image[ENDIAN_POS];
        proto     = image[PROTO_LO +: 2];
        tdis      = image[TIMER_POS];
        drive     = image[DRIVE_LO +: 2];
        delay     = image[DELAY_LO +: 3];
        enc_bad   = (rate > 4'(RATE_MAX)) ||
                    (mult_code == 3'd7) ||
                    (proto == WP_RSVD);
    end

endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader #(
    parameter int DIV         = 256,
    parameter int STREAM_BITS = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_in,
    input  logic       big_endian_pin,
    output logic       mode_clk,
    output logic       cfg_done,
    output logic       cfg_err,
    output logic [3:0] wb_rate,
    output logic [3:0] mult_factor,
    output logic       big_endian,
    output logic [1:0] wr_proto,
    output logic       timer_int_off,
    output logic [1:0] drive_code,
    output logic [2:0] wr_delay
);
    import bootmode_pkg::*;

    ld_state_t           state, state_nxt;
    logic                tick;
    logic [IMG_KEEP-1:0] image;
    logic                rsv_hit, last_bit;
    logic [3:0]          d_rate, d_factor;
    logic                d_be, d_tdis, d_bad;
    logic [1:0]          d_proto, d_drive;
    logic [2:0]          d_delay;
    logic                be_latched;

    bm_clkdiv #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .mode_clk(mode_clk), .tick(tick)
    );

    bm_capture #(.STREAM_BITS(STREAM_BITS), .KEEP(IMG_KEEP)) u_cap (
        .clk(clk), .rst_n(rst_n), .en(state == LD_SHIFT), .tick(tick),
        .mode_in(mode_in), .image(image), .rsv_hit(rsv_hit),
        .last_bit(last_bit)
    );

    bm_decode u_dec (
        .image(image), .rate(d_rate), .factor(d_factor), .be_bit(d_be),
        .proto(d_proto), .tdis(d_tdis), .drive(d_drive), .delay(d_delay),
        .enc_bad(d_bad)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            LD_SHIFT: if (last_bit) state_nxt = LD_CHECK;
            LD_CHECK: state_nxt = LD_DONE;
            LD_DONE:  state_nxt = LD_DONE;
            default:  state_nxt = LD_SHIFT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_SHIFT;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_done      <= 1'b0;
            cfg_err       <= 1'b0;
            wb_rate       <= '0;
            mult_factor   <= 4'd2;
            be_latched    <= 1'b0;
            wr_proto      <= WP_COMPAT;
            timer_int_off <= 1'b0;
            drive_code    <= DRIVE_DEFAULT;
            wr_delay      <= '0;
        end else if (state == LD_CHECK) begin
            cfg_done      <= 1'b1;
            cfg_err       <= rsv_hit || d_bad;
            wb_rate       <= d_rate;
            mult_factor   <= d_factor;
            be_latched    <= d_be;
            wr_proto      <= d_proto;
            timer_int_off <= d_tdis;
            drive_code    <= d_drive;
            wr_delay      <= d_delay;
        end
    end

    assign big_endian = big_endian_pin || (cfg_done && be_latched);

    a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);
    a_r13_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> cfg_done);
    a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
    a_r4_safe_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (wb_rate == 4'd0 && mult_factor == 4'd2 &&
                       wr_proto == 2'b00 && !timer_int_off &&
                       drive_code == 2'b10 && wr_delay == 3'd0));
    a_r13_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> ($stable(wb_rate) && $stable(mult_factor) &&
                      $stable(wr_proto) && $stable(wr_delay) &&
                      $stable(drive_code) && $stable(timer_int_off)));
    a_r6_factor_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && !cfg_err) |-> (mult_factor >= 4'd2 && mult_factor <= 4'd8));
    a_r7_pin_wins: assert property (@(posedge clk) disable iff (!rst_n)
        big_endian_pin |-> big_endian);

endmodule

// File: tb/boot_mode_loader_bench.sv
module boot_mode_loader_bench;
    localparam int DIV  = 8;
    localparam int BITS = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_in = 1'b0;
    logic pin = 1'b0;
    logic mode_clk, cfg_done, cfg_err, big_endian, timer_int_off;
    logic [3:0] wb_rate, mult_factor;
    logic [1:0] wr_proto, drive_code;
    logic [2:0] wr_delay;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    boot_mode_loader #(.DIV(DIV), .STREAM_BITS(BITS)) u_boot_mode_loader (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .big_endian_pin(pin),
        .mode_clk(mode_clk), .cfg_done(cfg_done), .cfg_err(cfg_err),
        .wb_rate(wb_rate), .mult_factor(mult_factor), .big_endian(big_endian),
        .wr_proto(wr_proto), .timer_int_off(timer_int_off),
        .drive_code(drive_code), .wr_delay(wr_delay)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mode_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic chk_defaults(input string req);
        chk({req, " rate"}, wb_rate, 0);
        chk({req, " mult"}, mult_factor, 2);
        chk({req, " proto"}, wr_proto, 0);
        chk({req, " timer"}, timer_int_off, 0);
        chk({req, " drive"}, drive_code, 2);
        chk({req, " delay"}, wr_delay, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 done", cfg_done, 0);
        chk("R1 err", cfg_err, 0);
        chk("R1 mode_clk", mode_clk, 1);
        chk_defaults("R4 in reset");
        rst_n = 1'b1;
        chk("R1 mode_clk after release", mode_clk, 1);
    endtask

    task automatic t_modeclk();
        do_reset();
        for (int n = 1; n <= 2 * DIV; n++) begin
            @(negedge clk);
            chk($sformatf("R2 mode_clk edge %0d", n), mode_clk,
                ((n % DIV) < DIV / 2) ? 1 : 0);
        end
    endtask

    task automatic t_stream(input string name, input int rate, input int mcode,
                            input int be, input int proto, input int tdis,
                            input int drv, input int dly, input int extra,
                            input logic pin_v, input int exp_err);
        logic [BITS-1:0] img;
        img = '0;
        img[4:1]   = 4'(rate);
        img[7:5]   = 3'(mcode);
        img[8]     = 1'(be);
        img[10:9]  = 2'(proto);
        img[11]    = 1'(tdis);
        img[14:13] = 2'(drv);
        img[24:22] = 3'(dly);
        if (extra >= 0) img[extra] = 1'b1;
        do_reset();
        pin = pin_v;
        for (int k = 0; k < BITS; k++) begin
            mode_in = img[k];
            if (k == 128) begin
                chk({name, " R4 mid done"}, cfg_done, 0);
                chk_defaults({name, " R4 mid"});
                chk({name, " R7 pin only"}, big_endian, int'(pin_v));
            end
            repeat (DIV) @(negedge clk);
        end
        chk({name, " R3 not yet done"}, cfg_done, 0);
        @(negedge clk);
        chk({name, " R3 done"}, cfg_done, 1);
        chk({name, " R13/R12 err"}, cfg_err, exp_err);
        chk({name, " R5 rate"}, wb_rate, rate);
        chk({name, " R6 mult"}, mult_factor, mcode + 2);
        chk({name, " R7 endian"}, big_endian, (be != 0 || pin_v) ? 1 : 0);
        chk({name, " R8 proto"}, wr_proto, proto);
        chk({name, " R9 timer"}, timer_int_off, tdis);
        chk({name, " R10 drive"}, drive_code, drv);
        chk({name, " R11 delay"}, wr_delay, dly);
        for (int k = 0; k < 2 * DIV; k++) begin
            mode_in = ~mode_in;
            @(negedge clk);
        end
        chk({name, " R13 rate frozen"}, wb_rate, rate);
        chk({name, " R13 delay frozen"}, wr_delay, dly);
        chk({name, " R13 err held"}, cfg_err, exp_err);
        chk({name, " R3 done held"}, cfg_done, 1);
        pin = ~pin_v;
        #1;
        chk({name, " R7 pin toggled"}, big_endian, (be != 0 || !pin_v) ? 1 : 0);
        pin = 1'b0;
    endtask

    initial begin
        t_reset();
        t_modeclk();
        t_stream("legal A", 8, 6, 0, 2, 1, 1, 7, -1, 1'b0, 0);
        t_stream("legal B", 0, 0, 1, 3, 0, 3, 3, 17, 1'b0, 0);
        t_stream("legal C", 3, 2, 0, 0, 0, 0, 0, 16, 1'b1, 0);
        t_stream("R5 rate9", 9, 1, 0, 0, 0, 2, 1, -1, 1'b0, 1);
        t_stream("R6 mult7", 2, 7, 0, 2, 0, 2, 0, -1, 1'b0, 1);
        t_stream("R8 proto01", 1, 1, 0, 1, 0, 2, 0, -1, 1'b0, 1);
        t_stream("R12 bit0", 1, 1, 0, 0, 0, 2, 0, 0, 1'b0, 1);
        t_stream("R12 bit12", 1, 1, 0, 0, 0, 2, 0, 12, 1'b0, 1);
        t_stream("R12 bit20", 1, 1, 0, 0, 0, 2, 0, 20, 1'b0, 1);
        t_stream("R12 bit200", 1, 1, 0, 0, 0, 2, 0, 200, 1'b0, 1);
        t_stream("R12 bit255", 1, 1, 0, 0, 0, 2, 0, 255, 1'b0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule